// File: doc/BRIEF.md
# Thermal Input Dwell Timer

This block measures how long an active-low thermal alarm input is held asserted. A free-running time base outside the block sends a one-cycle `tick` pulse per time quantum (22.76 ms in the system; the bench uses a much shorter pulse spacing). While the timer is enabled and the input is low, each tick adds one quantum to an 8-bit duration count. The count saturates at its top value and carries on across separate assertions until software reads the status register, which clears it.

The status register reports the count with a special rule for its lowest bit. For the first two quanta the lowest bit only shows that an assertion was seen, and the upper seven bits stay zero. From two quanta on, the register reads the full 8-bit count. The accumulated count is compared with a programmable 8-bit limit. When the input is asserted and the count is above the limit, a sticky interrupt status flag is set. A limit of zero sets the flag as soon as the input asserts. Software clears the flag by writing a one to it. A lock input makes the limit register read-only.

The register bus has single-cycle write and read strobes, a 2-bit address, and a combinational read data path. A read of the status register clears the count on the clock edge that ends the read cycle.

Top module: `therm_dwell_timer`

## Requirements
- R1: After reset the control, status, limit and interrupt registers all read 0x00 and `irq_flag` is low. The register addresses are: 0 = control (bit 0 is the enable), 1 = status, 2 = limit, 3 = interrupt (bit 0 is the flag).
- R2: While enabled and with `therm_n` low, a seen marker is set on the next clock edge. A read of the status register clears both the seen marker and the count on the edge that ends the read.
- R3: Each cycle with `tick` high while enabled and `therm_n` low adds one to the count. The count keeps its value between assertions and accumulates until a status read.
- R4: While the count is below 2, the status register reads 0x00 or 0x01, with bit 0 equal to the seen marker. At a count of 2 or more it reads the 8-bit count itself.
- R5: The count saturates at 0xFF and never wraps to zero.
- R6: While enabled and asserted, a count strictly greater than the limit sets `irq_flag` on the following clock edge. A count equal to the limit does not set it.
- R7: With a limit of 0x00, an enabled assertion sets `irq_flag` on the next edge, with no tick needed.
- R8: `irq_flag` is sticky. Only a write to the interrupt register with bit 0 = 1 clears it. Writing 0 to that bit has no effect.
- R9: While `lock` is high, writes to the limit register are ignored. With `lock` low, they take effect.
- R10: With the enable bit 0, an asserted input sets no seen marker, counts no ticks and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per time quantum |
| therm_n | input | 1 | Synchronized thermal input, active low |
| lock | input | 1 | Global lock; high makes the limit register read-only |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears the count) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from address |
| irq_flag | output | 1 | Sticky interrupt status flag |

## Verification
The bench checks the status view at the point where it switches over. A single quantum reads 0x01. Four quanta read 0x04, which has bit 0 clear even though the input was seen. A design that ORs the seen marker into the count would read 0x05 there. The interrupt is checked on both sides of a limit of 5: five quanta must leave `irq_flag` low and six must raise it. A design that compares with greater-or-equal, or that ignores the zero-limit rule, fails one of these checks.

The bench also checks the following:
- 300 ticks must read 0xFF with no interrupt against a limit of 0xFF. This catches a count that wraps.
- A write of 0 to the interrupt register must leave the flag set.
- A locked limit write must leave the old value.
- A disabled timer must leave every register at zero even with the input held low and ticks arriving.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_STATUS = 2'd1,
        REG_LIMIT  = 2'd2,
        REG_IRQ    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        reg_sel_e      sel;
        logic [DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [DW-1:0] count;
        logic          seen;
    } dwell_t;

    // Below the threshold only the seen marker shows; from it on, the raw count.
    function automatic logic [DW-1:0] status_view(dwell_t d, logic [DW-1:0] thresh);
        if (d.count >= thresh)
            return d.count;
        else
            return {{(DW-1){1'b0}}, d.seen};
    endfunction

endpackage

// File: rtl/tdt_dwell_counter.sv
module tdt_dwell_counter
    import tdt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   tick,
    input  logic   clr,
    output dwell_t st
);
    localparam logic [DW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (clr) begin
            st <= '0;
        end else begin
            if (active)
                st.seen <= 1'b1;
            if (active && tick && (st.count != TOP))
                st.count <= st.count + 1'b1;
        end
    end
endmodule

// File: rtl/tdt_limit_flag.sv
module tdt_limit_flag
    import tdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] limit,
    input  logic          clr,
    output logic          flag
);
    logic over;

    always_comb begin
        over = active && ((limit == '0) || (count > limit));
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else
            flag <= over | (flag & ~clr);
    end
endmodule

// File: rtl/tdt_regfile.sv
module tdt_regfile
    import tdt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          lock,
    input  logic [DW-1:0] status,
    input  logic          flag,
    output logic          en,
    output logic [DW-1:0] limit,
    output logic [DW-1:0] rdata,
    output logic          stat_clr,
    output logic          flag_clr
);
    always_comb begin
        stat_clr = req.rd && (req.sel == REG_STATUS);
        flag_clr = req.wr && (req.sel == REG_IRQ) && req.wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            limit <= '0;
        end else if (req.wr) begin
            if (req.sel == REG_CTRL)
                en <= req.wdata[0];
            if ((req.sel == REG_LIMIT) && !lock)
                limit <= req.wdata;
        end
    end

    always_comb begin
        case (req.sel)
            REG_CTRL:   rdata = {{(DW-1){1'b0}}, en};
            REG_STATUS: rdata = status;
            REG_LIMIT:  rdata = limit;
            REG_IRQ:    rdata = {{(DW-1){1'b0}}, flag};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/therm_dwell_timer.sv
module therm_dwell_timer
    import tdt_pkg::*;
#(
    parameter int SEEN_QUANTA = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       therm_n,
    input  logic       lock,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_flag
);
    localparam logic [DW-1:0] THRESH = DW'(SEEN_QUANTA);

    bus_req_t      req;
    dwell_t        dwell;
    logic          en_q;
    logic [DW-1:0] limit_q;
    logic [DW-1:0] cnt_now;
    logic [DW-1:0] stat_view;
    logic          active;
    logic          stat_clr;
    logic          flag_clr;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.sel   = reg_sel_e'(bus_addr);
        req.wdata = bus_wdata;
        active    = en_q && !therm_n;
        cnt_now   = dwell.count;
        stat_view = status_view(dwell, THRESH);
    end

    tdt_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .lock     (lock),
        .status   (stat_view),
        .flag     (irq_flag),
        .en       (en_q),
        .limit    (limit_q),
        .rdata    (bus_rdata),
        .stat_clr (stat_clr),
        .flag_clr (flag_clr)
    );

    tdt_dwell_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tick   (tick),
        .clr    (stat_clr),
        .st     (dwell)
    );

    tdt_limit_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .count  (dwell.count),
        .limit  (limit_q),
        .clr    (flag_clr),
        .flag   (irq_flag)
    );
endmodule

// File: rtl/tdt_checker.sv
module tdt_checker (
    input logic       clk,
    input logic       rst,
    input logic       therm_n,
    input logic       lock,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       en,
    input logic [7:0] limit,
    input logic [7:0] cnt,
    input logic       irq
);
    logic stat_rd;
    logic irq_w1;
    assign stat_rd = bus_rd && (bus_addr == 2'd1);
    assign irq_w1  = bus_wr && (bus_addr == 2'd3) && bus_wdata[0];

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (cnt == 8'd0)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 8'd1))); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == 8'hFF) && !stat_rd |=> (cnt == 8'hFF)); // R5
    AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (rst)
        en && !therm_n && (limit == 8'd0) |=> irq); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_w1 |=> irq); // R8
    AST_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(limit)); // R9
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en && !stat_rd |=> $stable(cnt)); // R10
endmodule

bind therm_dwell_timer tdt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .therm_n   (therm_n),
    .lock      (lock),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en        (en_q),
    .limit     (limit_q),
    .cnt       (cnt_now),
    .irq       (irq_flag)
);

// File: tb/tb_therm_dwell_timer.sv
module tb_therm_dwell_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       therm_n = 1'b1;
    logic       lock = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_LIM = 2'd2, A_IRQ = 2'd3;

    always #10 clk = ~clk; // 50 MHz

    therm_dwell_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .therm_n(therm_n), .lock(lock),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flag(irq_flag)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b1;
        bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the expected item for each read cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd) begin
                if (sb_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check(bus_rdata, it.exp, it.tag);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check({7'd0, irq_flag}, 8'd0, "R1 irq pin after reset");
        rd_expect(A_CTRL, 8'h00, "R1 ctrl reset");
        rd_expect(A_STAT, 8'h00, "R1 status reset");
        rd_expect(A_LIM,  8'h00, "R1 limit reset");
        rd_expect(A_IRQ,  8'h00, "R1 irq reset");

        // R10 disabled: nothing reacts (limit is 0 here, so R7 would fire if enabled)
        @(negedge clk) therm_n = 1'b0;
        ticks(3);
        idle(1);
        check({7'd0, irq_flag}, 8'd0, "R10 irq pin while disabled");
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'h00, "R10 status while disabled");
        rd_expect(A_IRQ,  8'h00, "R10 irq reg while disabled");

        // R9 limit write unlocked, then enable
        wr_reg(A_LIM, 8'd5);
        rd_expect(A_LIM, 8'd5, "R9 unlocked limit write");
        wr_reg(A_CTRL, 8'h01);
        rd_expect(A_CTRL, 8'h01, "R1 ctrl enable bit");

        // R2 seen marker and clear-on-read
        @(negedge clk) therm_n = 1'b0;
        idle(2);
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'h01, "R2 seen marker set");
        rd_expect(A_STAT, 8'h00, "R2 cleared by read");

        // R4 one quantum shows only the marker
        @(negedge clk) therm_n = 1'b0;
        ticks(1);
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'h01, "R4 count 1 shows seen only");

        // R4 four quanta: full count, bit 0 is count lsb
        @(negedge clk) therm_n = 1'b0;
        ticks(4);
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'h04, "R4 count 4 raw reading");

        // R3 accumulation across two assertions
        @(negedge clk) therm_n = 1'b0;
        ticks(2);
        @(negedge clk) therm_n = 1'b1;
        ticks(3);
        @(negedge clk) therm_n = 1'b0;
        ticks(2);
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'h04, "R3 accumulate 2+2, ticks while high ignored");
        rd_expect(A_IRQ,  8'h00, "R6 count 4 below limit 5");

        // R6 boundary: equal to limit no irq, above limit irq
        @(negedge clk) therm_n = 1'b0;
        ticks(5);
        idle(1);
        check({7'd0, irq_flag}, 8'd0, "R6 count equal to limit");
        ticks(1);
        idle(1);
        check({7'd0, irq_flag}, 8'd1, "R6 count above limit");
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_IRQ,  8'h01, "R6 irq register set");
        rd_expect(A_STAT, 8'h06, "R3 count 6");

        // R8 sticky, write-one-to-clear
        wr_reg(A_IRQ, 8'h00);
        rd_expect(A_IRQ, 8'h01, "R8 write 0 keeps flag");
        wr_reg(A_IRQ, 8'h01);
        rd_expect(A_IRQ, 8'h00, "R8 write 1 clears flag");
        check({7'd0, irq_flag}, 8'd0, "R8 pin cleared");

        // R7 zero limit fires on assertion alone
        wr_reg(A_LIM, 8'h00);
        @(negedge clk) therm_n = 1'b0;
        idle(1);
        check({7'd0, irq_flag}, 8'd1, "R7 zero limit immediate");
        @(negedge clk) therm_n = 1'b1;
        wr_reg(A_IRQ, 8'h01);
        rd_expect(A_STAT, 8'h01, "R2 seen after short assertion");

        // R5 saturation; limit 0xFF never exceeded
        wr_reg(A_LIM, 8'hFF);
        @(negedge clk) therm_n = 1'b0;
        ticks(300);
        @(negedge clk) therm_n = 1'b1;
        rd_expect(A_STAT, 8'hFF, "R5 saturated count");
        rd_expect(A_IRQ,  8'h00, "R6 count 0xFF not above limit 0xFF");
        rd_expect(A_STAT, 8'h00, "R2 cleared after saturation");

        // R9 lock
        @(negedge clk) lock = 1'b1;
        wr_reg(A_LIM, 8'h10);
        rd_expect(A_LIM, 8'hFF, "R9 locked write ignored");
        @(negedge clk) lock = 1'b0;
        wr_reg(A_LIM, 8'h10);
        rd_expect(A_LIM, 8'h10, "R9 write after unlock");

        idle(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule